// File: doc/BRIEF.md
# Paged Long Address Translator

This block converts a 16-bit logical data address into a wide physical address using a small bank of page pointers. The two most significant logical bits choose one of four page pointers. The chosen page number becomes the upper part of the physical address, and the remaining 14 logical bits pass through unchanged as the in-page offset. A caller may also supply its own page number for one request, and that page then takes the place of the pointer lookup.

The pointers are loaded through a simple write port. After reset they hold 0, 1, 2 and 3, so each logical address lands on the same numbered physical location in the lowest segment. Byte requests may use any address. A word request at an odd byte address is not translated: the block raises a one-cycle alignment trap and gives no valid strobe for that request. With the default page width of 10 bits the physical address is 24 bits wide. A page width of 4 gives an 18-bit address from the same logic.

Top module: `paged_addr_xlat`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `phys_valid` and `align_trap` are 0 and `phys_addr` is 0.
- R2: A request accepted at a clock edge (with `req_valid`=1) that is not trapped drives `phys_valid`=1 for exactly the next cycle. `phys_addr` = {page, `req_addr[13:0]`}, and the page comes from pointer number `req_addr[15:14]`.
- R3: After reset the pointers hold 0, 1, 2 and 3. With no pointer writes and no override, every untrapped request therefore yields `phys_addr` equal to the zero-extended logical address.
- R4: A request with `req_word`=1 (word access) and `req_addr[0]`=1 raises `align_trap` for exactly one cycle. In that cycle `phys_valid` is 0 and `phys_addr` keeps its previous value.
- R5: A request with `req_word`=0 (byte access) is translated at any address, odd or even. A word request at an even address is also translated.
- R6: When `req_ovr_en`=1, the page field of `phys_addr` equals `req_ovr_page`, and the pointer selected by `req_addr[15:14]` is not used.
- R7: When `ptr_wr_en`=1 at a clock edge, pointer `ptr_wr_idx` takes `ptr_wr_data`. Requests from the next cycle on use the new value. A request at that same edge still uses the old value.
- R8: In a cycle after an edge with `req_valid`=0, `phys_valid` and `align_trap` are 0. Whenever `phys_valid` is 0, `phys_addr` holds its value.
- R9: With `PAGE_W`=4 the physical address is 18 bits wide, and R1 to R8 hold with 4-bit page numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr_en | input | 1 | Pointer write enable |
| ptr_wr_idx | input | 2 | Index of the pointer to write |
| ptr_wr_data | input | PAGE_W | New page number |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_ovr_en | input | 1 | Use `req_ovr_page` in place of the pointer |
| req_ovr_page | input | PAGE_W | Override page number |
| phys_addr | output | PAGE_W+14 | Registered physical address |
| phys_valid | output | 1 | One-cycle strobe for a translated request |
| align_trap | output | 1 | One-cycle strobe for a misaligned word request |

## Verification
The bench aims at word requests at odd addresses that follow a valid translation. A design that let the trap through as a translation, or that changed `phys_addr` on a trap, shows up at once. It also issues a pointer write and a request to the same pointer in the same cycle. A design that forwarded the new value, or that wrote the wrong index, then produces a wrong page. Overrides go to every quadrant, which catches a design that ignores the override or uses it only for some selections. Odd-address byte requests catch a trap check that forgets the access size. A second instance with 4-bit pages runs the same stimulus and catches any hidden 24-bit assumption.

// File: rtl/pax_pkg.sv
package pax_pkg;
  localparam int LA_W  = 16;
  localparam int NPTR  = 4;
  localparam int SEL_W = $clog2(NPTR);
  localparam int OFS_W = LA_W - SEL_W;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/pax_ptr_file.sv
module pax_ptr_file
  import pax_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [PAGE_W-1:0] rd_page
);
  logic [PAGE_W-1:0] page_q [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [PAGE_W-1:0] INIT = PAGE_W'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        page_q[g] <= INIT;
      end else if (wr_en && (wr_idx == SEL_W'(g))) begin
        page_q[g] <= wr_data;
      end
    end

    // R7: a write lands in the addressed pointer only
    a_r7_ptr_write: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && ($past(wr_idx) == SEL_W'(g)))
        |-> (page_q[g] == $past(wr_data)));
    a_r7_ptr_keep: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($past(wr_en) && ($past(wr_idx) == SEL_W'(g))))
        |-> $stable(page_q[g]));
  end

  assign rd_page = page_q[rd_idx];
endmodule

// File: rtl/pax_align_chk.sv
module pax_align_chk
  import pax_pkg::*;
(
  input  logic      req_valid,
  input  acc_size_e req_size,
  input  logic      addr_lsb,
  output logic      accept,
  output logic      trap
);
  logic misaligned;

  always_comb begin
    misaligned = (req_size == ACC_WORD) && addr_lsb;
    trap       = req_valid && misaligned;
    accept     = req_valid && !misaligned;
  end
endmodule

// File: rtl/pax_addr_form.sv
module pax_addr_form
  import pax_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int PA_W  = PAGE_W + OFS_W
) (
  input  logic [PAGE_W-1:0] ptr_page,
  input  logic              ovr_en,
  input  logic [PAGE_W-1:0] ovr_page,
  input  logic [OFS_W-1:0]  offset,
  output logic [PA_W-1:0]   phys
);
  logic [PAGE_W-1:0] page_sel;

  always_comb begin
    page_sel = ovr_en ? ovr_page : ptr_page;
    phys     = {page_sel, offset};
  end
endmodule

// File: rtl/paged_addr_xlat.sv
module paged_addr_xlat
  import pax_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int PA_W  = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_wr_en,
  input  logic [SEL_W-1:0]  ptr_wr_idx,
  input  logic [PAGE_W-1:0] ptr_wr_data,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_addr,
  input  logic              req_word,
  input  logic              req_ovr_en,
  input  logic [PAGE_W-1:0] req_ovr_page,
  output logic [PA_W-1:0]   phys_addr,
  output logic              phys_valid,
  output logic              align_trap
);
  logic [PAGE_W-1:0] ptr_page;
  logic [PA_W-1:0]   phys_next;
  logic              accept;
  logic              trap;
  acc_size_e         req_size;

  assign req_size = req_word ? ACC_WORD : ACC_BYTE;

  pax_ptr_file #(.PAGE_W(PAGE_W)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ptr_wr_en),
    .wr_idx  (ptr_wr_idx),
    .wr_data (ptr_wr_data),
    .rd_idx  (req_addr[LA_W-1 -: SEL_W]),
    .rd_page (ptr_page)
  );

  pax_align_chk u_align (
    .req_valid (req_valid),
    .req_size  (req_size),
    .addr_lsb  (req_addr[0]),
    .accept    (accept),
    .trap      (trap)
  );

  pax_addr_form #(.PAGE_W(PAGE_W)) u_form (
    .ptr_page (ptr_page),
    .ovr_en   (req_ovr_en),
    .ovr_page (req_ovr_page),
    .offset   (req_addr[OFS_W-1:0]),
    .phys     (phys_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr  <= '0;
      phys_valid <= 1'b0;
      align_trap <= 1'b0;
    end else begin
      phys_valid <= accept;
      align_trap <= trap;
      if (accept) begin
        phys_addr <= phys_next;
      end
    end
  end

  // R4: trap and valid never together
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(align_trap && phys_valid));
  // R4: a trap only follows a word request at an odd address
  a_r4_trap_cause: assert property (@(posedge clk) disable iff (rst)
    align_trap |-> $past(req_valid && req_word && req_addr[0]));
  // R5: byte requests and even word requests are always translated
  a_r5_accepted: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && !$past(req_word && req_addr[0]))
      |-> phys_valid);
  // R2: the offset passes through unchanged
  a_r2_offset: assert property (@(posedge clk) disable iff (rst)
    phys_valid |-> (phys_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0])));
  // R6: an override supplies the page field
  a_r6_override: assert property (@(posedge clk) disable iff (rst)
    (phys_valid && $past(req_ovr_en))
      |-> (phys_addr[PA_W-1:OFS_W] == $past(req_ovr_page)));
  // R8: no request, no strobes
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid)) |-> (!phys_valid && !align_trap));
  // R8: the address holds while no translation is reported
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !phys_valid |-> $stable(phys_addr));
endmodule

// File: tb/paged_addr_xlat_tb.sv
module paged_addr_xlat_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_wr_en = 1'b0;
  logic [1:0]  ptr_wr_idx = '0;
  logic [9:0]  ptr_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_ovr_en = 1'b0;
  logic [9:0]  req_ovr_page = '0;

  logic [23:0] phys_addr;
  logic        phys_valid, align_trap;
  logic [17:0] phys_addr18;
  logic        phys_valid18, align_trap18;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  string       phase = "R1 reset";

  // reference model state
  logic [9:0]  m_ptr [4];
  logic [3:0]  m_ptr18 [4];
  logic [23:0] e_phys;
  logic [17:0] e_phys18;
  logic        e_valid, e_trap;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  paged_addr_xlat #(.PAGE_W(10)) u_dut (
    .clk(clk), .rst(rst), .ptr_wr_en(ptr_wr_en), .ptr_wr_idx(ptr_wr_idx),
    .ptr_wr_data(ptr_wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_ovr_en(req_ovr_en), .req_ovr_page(req_ovr_page),
    .phys_addr(phys_addr), .phys_valid(phys_valid), .align_trap(align_trap)
  );

  paged_addr_xlat #(.PAGE_W(4)) u_dut18 (
    .clk(clk), .rst(rst), .ptr_wr_en(ptr_wr_en), .ptr_wr_idx(ptr_wr_idx),
    .ptr_wr_data(ptr_wr_data[3:0]), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_ovr_en(req_ovr_en), .req_ovr_page(req_ovr_page[3:0]),
    .phys_addr(phys_addr18), .phys_valid(phys_valid18), .align_trap(align_trap18)
  );

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_ptr[i]   = 10'(i);
        m_ptr18[i] = 4'(i);
      end
      e_phys = '0; e_phys18 = '0; e_valid = 1'b0; e_trap = 1'b0;
    end else begin
      e_valid = 1'b0;
      e_trap  = 1'b0;
      if (req_valid) begin
        if (req_word && req_addr[0]) begin
          e_trap = 1'b1;
        end else begin
          e_valid  = 1'b1;
          e_phys   = {(req_ovr_en ? req_ovr_page : m_ptr[req_addr[15:14]]), req_addr[13:0]};
          e_phys18 = {(req_ovr_en ? req_ovr_page[3:0] : m_ptr18[req_addr[15:14]]), req_addr[13:0]};
        end
      end
      if (ptr_wr_en) begin
        m_ptr[ptr_wr_idx]   = ptr_wr_data;
        m_ptr18[ptr_wr_idx] = ptr_wr_data[3:0];
      end
    end
  end

  task automatic check(input string what, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    check("phys_addr",    phys_addr,            e_phys);
    check("phys_valid",   24'(phys_valid),      24'(e_valid));
    check("align_trap",   24'(align_trap),      24'(e_trap));
    check("R9 phys18",    24'(phys_addr18),     24'(e_phys18));
    check("R9 valid18",   24'(phys_valid18),    24'(e_valid));
    check("R9 trap18",    24'(align_trap18),    24'(e_trap));
  endtask

  // inputs change just after a falling edge; outputs compared at the next one
  task automatic cyc(input logic rv, input logic [15:0] a, input logic w,
                     input logic oe, input logic [9:0] op,
                     input logic we, input logic [1:0] wi, input logic [9:0] wd);
    req_valid = rv; req_addr = a; req_word = w;
    req_ovr_en = oe; req_ovr_page = op;
    ptr_wr_en = we; ptr_wr_idx = wi; ptr_wr_data = wd;
    @(negedge clk);
    compare();
  endtask

  task automatic req(input logic [15:0] a, input logic w);
    cyc(1'b1, a, w, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic idle();
    cyc(1'b0, 16'h0, 1'b0, 1'b0, '0, 1'b0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    phase = "R1 reset";
    repeat (3) cyc(1'b1, 16'hC123, 1'b0, 1'b0, '0, 1'b1, 2'd3, 10'h3FF);
    rst = 1'b0;
    idle();

    phase = "R3 identity";
    for (int q = 0; q < 4; q++) begin
      req(16'(q * 16'h4000 + 16'h0124), 1'b1);
      req(16'(q * 16'h4000 + 16'h3FFE), 1'b0);
    end
    req(16'hFFFF, 1'b0);
    req(16'h0000, 1'b1);

    phase = "R5 byte odd";
    req(16'h4001, 1'b0);
    req(16'h8FFF, 1'b0);

    phase = "R4 word odd trap";
    req(16'h1234, 1'b1);
    req(16'h1235, 1'b1);
    req(16'hC001, 1'b1);
    req(16'h7FFF, 1'b1);
    req(16'h2002, 1'b1);

    phase = "R8 idle";
    idle(); idle();

    phase = "R7 pointer write";
    cyc(1'b0, 16'h0, 1'b0, 1'b0, '0, 1'b1, 2'd1, 10'h2A5);
    req(16'h4010, 1'b1);
    req(16'h0010, 1'b1);
    // write and request to the same pointer in one cycle
    cyc(1'b1, 16'hC020, 1'b0, 1'b0, '0, 1'b1, 2'd3, 10'h15A);
    req(16'hC020, 1'b0);
    cyc(1'b1, 16'h8004, 1'b1, 1'b0, '0, 1'b1, 2'd0, 10'h3C7);
    req(16'h0006, 1'b1);
    req(16'h8006, 1'b1);

    phase = "R6 override";
    for (int q = 0; q < 4; q++) begin
      cyc(1'b1, 16'(q * 16'h4000 + 16'h0100), 1'b1, 1'b1, 10'(10'h301 + q), 1'b0, '0, '0);
    end
    cyc(1'b1, 16'h4003, 1'b1, 1'b1, 10'h0FF, 1'b0, '0, '0);
    req(16'h4100, 1'b0);

    phase = "R2 mixed";
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3] | lfsr[7], {lfsr[6:0], lfsr[15:7]}, lfsr[2], lfsr[9] & lfsr[4],
          {lfsr[11:6], lfsr[3:0]}, lfsr[12] & lfsr[5], lfsr[14:13], lfsr[9:0]);
    end
    idle();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule